// File: doc/BRIEF.md
# Asynchronous Transmit Descriptor Sequencer

This block is a control engine that sends one asynchronous packet at a time. When a transmit context is pending, it fetches that context's two-word descriptor block from host memory through a single-outstanding read request/response port. It then reads the payload words from host memory into a local packet FIFO. Once the whole packet is held locally, it raises a transfer request toward the link layer, which pops the words out of the FIFO.

The link reports each attempt as accepted, busy (retry wanted) or failed hard. On busy, the engine replays the same packet from its first word without touching memory again. This continues until a programmable retry limit is used up. Every stage can end the sequence early with an error code. A one-cycle completion pulse carries the final status and the context that was served.

Several contexts (by default two: index 0 for requests, index 1 for responses) share the same logic and differ only in the base address of their descriptor. Header formation, CRC and the host bus protocol sit outside this block.

Top module: `async_tx_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mem_req`, `lnk_req` and `done` are low.
- R2: At idle, the lowest-index pending context is served first; `done_ctx` reports the index of the context whose sequence ended.
- R3: A sequence begins with exactly two memory reads, at the context base address and base+1, both completed before any payload read. Word 0 bits [15:0] give the payload length in words, and word 1 bits [AW-1:0] give the payload address.
- R4: Payload words are read from consecutive addresses starting at the payload address and enter the FIFO in order. Each `lnk_pop` cycle in the transfer stage presents the next word on `lnk_data` one cycle later.
- R5: A length of zero skips the payload stage: `lnk_req` rises right after the second descriptor read, and only two memory reads occur.
- R6: A length above DEPTH ends the sequence with status 5 (length error) after the two descriptor reads, with no payload read and no link request.
- R7: An error response to a descriptor read ends the sequence with status 1. An error response to a payload read ends it with status 2. In both cases there are no further reads and no link request.
- R8: A `lnk_busy` while retries remain keeps `lnk_req` high, and the next attempt pops the packet again from its first word.
- R9: A `lnk_busy` received after `retry_limit` retries have already been made ends the sequence with status 3, so exactly `retry_limit`+1 attempts are made.
- R10: A `lnk_err` during a transfer ends the sequence with status 4.
- R11: A `lnk_ok` ends the sequence with status 0. `done` is high for exactly one cycle per sequence.
- R12: The FIFO is emptied at every sequence end, so the next packet's words start from its own first word.
- R13: `mem_req` and `lnk_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_pend | input | NCTX | Per-context transmit pending level |
| ctx_base | input | NCTX*AW | Descriptor base address per context, context i at bits [i*AW +: AW] |
| retry_limit | input | RW | Maximum number of retries after the first attempt |
| mem_req | output | 1 | Memory read request, held until a response arrives |
| mem_addr | output | AW | Word address of the pending read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | DW | Read response data |
| mem_rsp_err | input | 1 | Read response carries an error |
| lnk_req | output | 1 | Packet ready in FIFO, transfer requested |
| lnk_pop | input | 1 | Link takes the next FIFO word |
| lnk_data | output | DW | FIFO word, valid the cycle after a pop |
| lnk_ok | input | 1 | Attempt accepted |
| lnk_busy | input | 1 | Attempt refused or failed, retry wanted |
| lnk_err | input | 1 | Hard link failure |
| done | output | 1 | One-cycle end-of-sequence pulse |
| done_ctx | output | CW | Context served by the ended sequence |
| done_status | output | 3 | End code: 0 ok, 1 descriptor error, 2 payload error, 3 retries used up, 4 link error, 5 length error |

## Verification
A wrong internal state shows up at the ports within a few cycles. A bad descriptor latch or address counter sends a wrong address on the very next `mem_addr` request. A FIFO pointer that is not rewound or not flushed puts a wrong word on `lnk_data` one cycle after the first pop of the following attempt or packet. A miscounted retry changes the number of link attempts seen before `done`, and it changes the status code on that pulse.

// File: rtl/atx_pkg.sv
`timescale 1ns/1ps
package atx_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_DESC,
    SQ_DATA,
    SQ_XFER,
    SQ_DONE
  } atx_state_e;

  typedef enum logic [2:0] {
    TXS_OK        = 3'd0,
    TXS_DESC_ERR  = 3'd1,
    TXS_DATA_ERR  = 3'd2,
    TXS_RETRY_EXH = 3'd3,
    TXS_LINK_ERR  = 3'd4,
    TXS_LEN_ERR   = 3'd5
  } atx_status_e;
endpackage

// File: rtl/atx_pick.sv
`timescale 1ns/1ps
// Fixed-priority context selector: lowest pending index wins.
module atx_pick #(
  parameter int NCTX = 2,
  parameter int AW   = 16,
  parameter int CW   = 1
) (
  input  logic [NCTX-1:0]    pend,
  input  logic [NCTX*AW-1:0] bases,
  output logic               any,
  output logic [CW-1:0]      idx,
  output logic [AW-1:0]      base
);
  logic [AW-1:0] base_arr [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : g_base
    assign base_arr[g] = bases[g*AW +: AW];
  end

  always_comb begin
    any  = |pend;
    idx  = '0;
    base = base_arr[0];
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx  = CW'(i);
        base = base_arr[i];
      end
    end
  end
endmodule

// File: rtl/atx_retry.sv
`timescale 1ns/1ps
// Retry counter, cleared between packets.
module atx_retry #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [RW-1:0] limit,
  output logic          exhausted
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted = (cnt_q == limit);
endmodule

// File: rtl/atx_fifo.sv
`timescale 1ns/1ps
// Packet FIFO with synchronous read, rewind of the read side, and flush.
module atx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          rewind,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rewind) begin
        rd_ptr <= '0;
      end else if (rd_en) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rd_data <= store[rd_ptr];
      end
    end
  end
endmodule

// File: rtl/async_tx_seq.sv
`timescale 1ns/1ps
module async_tx_seq
  import atx_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int NCTX  = 2,
  parameter int RW    = 4,
  parameter int LW    = 16,
  localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCTX-1:0]  ctx_pend,
  input  logic [NCTX*AW-1:0] ctx_base,
  input  logic [RW-1:0]    retry_limit,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             lnk_req,
  input  logic             lnk_pop,
  output logic [DW-1:0]    lnk_data,
  input  logic             lnk_ok,
  input  logic             lnk_busy,
  input  logic             lnk_err,
  output logic             done,
  output logic [CW-1:0]    done_ctx,
  output logic [2:0]       done_status
);
  atx_state_e    state;
  logic [CW-1:0] ctx_q;
  logic          idx_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] left_q;

  logic          pick_any;
  logic [CW-1:0] pick_idx;
  logic [AW-1:0] pick_base;
  logic          exh;
  logic          rsp_take, rsp_good;
  logic          fin;
  atx_status_e   fin_code;
  logic          replay;
  logic          fifo_wr, fifo_rd;

  atx_pick #(.NCTX(NCTX), .AW(AW), .CW(CW)) u_pick (
    .pend (ctx_pend),
    .bases(ctx_base),
    .any  (pick_any),
    .idx  (pick_idx),
    .base (pick_base)
  );

  atx_retry #(.RW(RW)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clr      (state == SQ_IDLE),
    .inc      (replay),
    .limit    (retry_limit),
    .exhausted(exh)
  );

  atx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .flush  (fin),
    .rewind (replay),
    .wr_en  (fifo_wr),
    .wr_data(mem_rsp_data),
    .rd_en  (fifo_rd),
    .rd_data(lnk_data)
  );

  assign rsp_take = mem_req && mem_rsp_valid;
  assign rsp_good = rsp_take && !mem_rsp_err;
  assign fifo_wr  = (state == SQ_DATA) && rsp_good;
  assign fifo_rd  = (state == SQ_XFER) && lnk_req && lnk_pop;
  assign replay   = (state == SQ_XFER) && lnk_busy && !lnk_err && !exh;

  // Decide whether this cycle ends the sequence, and with which code.
  always_comb begin
    fin      = 1'b0;
    fin_code = TXS_OK;
    unique case (state)
      SQ_DESC: begin
        if (rsp_take && mem_rsp_err) begin
          fin      = 1'b1;
          fin_code = TXS_DESC_ERR;
        end else if (rsp_take && idx_q && (len_q > LW'(DEPTH))) begin
          fin      = 1'b1;
          fin_code = TXS_LEN_ERR;
        end
      end
      SQ_DATA: begin
        if (rsp_take && mem_rsp_err) begin
          fin      = 1'b1;
          fin_code = TXS_DATA_ERR;
        end
      end
      SQ_XFER: begin
        if (lnk_err) begin
          fin      = 1'b1;
          fin_code = TXS_LINK_ERR;
        end else if (lnk_busy) begin
          fin      = exh;
          fin_code = TXS_RETRY_EXH;
        end else if (lnk_ok) begin
          fin      = 1'b1;
          fin_code = TXS_OK;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      ctx_q       <= '0;
      idx_q       <= 1'b0;
      len_q       <= '0;
      left_q      <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      lnk_req     <= 1'b0;
      done        <= 1'b0;
      done_ctx    <= '0;
      done_status <= TXS_OK;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (pick_any) begin
            ctx_q    <= pick_idx;
            mem_addr <= pick_base;
            mem_req  <= 1'b1;
            idx_q    <= 1'b0;
            state    <= SQ_DESC;
          end
        end
        SQ_DESC: begin
          if (rsp_good) begin
            if (!idx_q) begin
              len_q    <= mem_rsp_data[LW-1:0];
              idx_q    <= 1'b1;
              mem_addr <= mem_addr + 1'b1;
            end else if (len_q == '0) begin
              mem_req <= 1'b0;
              lnk_req <= 1'b1;
              state   <= SQ_XFER;
            end else begin
              mem_addr <= mem_rsp_data[AW-1:0];
              left_q   <= len_q;
              state    <= SQ_DATA;
            end
          end
        end
        SQ_DATA: begin
          if (rsp_good) begin
            mem_addr <= mem_addr + 1'b1;
            left_q   <= left_q - 1'b1;
            if (left_q == LW'(1)) begin
              mem_req <= 1'b0;
              lnk_req <= 1'b1;
              state   <= SQ_XFER;
            end
          end
        end
        SQ_XFER: ;
        SQ_DONE: begin
          done  <= 1'b0;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase

      if (fin) begin
        state       <= SQ_DONE;
        mem_req     <= 1'b0;
        lnk_req     <= 1'b0;
        done        <= 1'b1;
        done_ctx    <= ctx_q;
        done_status <= fin_code;
      end
    end
  end
endmodule

// File: rtl/atx_seq_chk.sv
`timescale 1ns/1ps
module atx_seq_chk
  import atx_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       mem_req,
  input logic       mem_rsp_valid,
  input logic       mem_rsp_err,
  input logic       lnk_req,
  input logic       lnk_ok,
  input logic       lnk_busy,
  input logic       lnk_err,
  input logic       done,
  input logic [2:0] done_status
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mem_req && !lnk_req && !done));

  // R13
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && lnk_req));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  ok_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_status == TXS_OK) |-> $past(lnk_ok));

  // R7
  mem_err_end_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rsp_valid && mem_rsp_err) |=>
      (done && (done_status == TXS_DESC_ERR || done_status == TXS_DATA_ERR)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lnk_req && lnk_busy && !lnk_err) |=>
      (lnk_req || (done && done_status == TXS_RETRY_EXH)));

  // R10
  link_err_end_chk: assert property (@(posedge clk) disable iff (rst)
    (lnk_req && lnk_err) |=> (done && done_status == TXS_LINK_ERR));
endmodule

bind async_tx_seq atx_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_req      (mem_req),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_err  (mem_rsp_err),
  .lnk_req      (lnk_req),
  .lnk_ok       (lnk_ok),
  .lnk_busy     (lnk_busy),
  .lnk_err      (lnk_err),
  .done         (done),
  .done_status  (done_status)
);

// File: tb/async_tx_seq_tb.sv
`timescale 1ns/1ps
module async_tx_seq_tb;
  localparam int AW = 16, DW = 32, DEPTH = 8, NCTX = 2, RW = 4;
  localparam logic [15:0] BASE0 = 16'h0100;
  localparam logic [15:0] BASE1 = 16'h0240;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    ctx_pend;
  logic [3:0]    retry_limit;
  logic          mem_req;
  logic [15:0]   mem_addr;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_data;
  logic          mem_rsp_err;
  logic          lnk_req;
  logic          lnk_pop, lnk_ok, lnk_busy, lnk_err;
  logic [31:0]   lnk_data;
  logic          done;
  logic [0:0]    done_ctx;
  logic [2:0]    done_status;

  int checks = 0;
  int errors = 0;

  logic [15:0] d_cnt   [2];
  logic [15:0] d_paddr [2];
  logic        err_on;
  logic [15:0] err_addr;
  logic [15:0] rd_log [32];
  int          nlog;

  always #10 clk = ~clk;

  async_tx_seq #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NCTX(NCTX), .RW(RW)) u_dut (
    .clk(clk), .rst(rst), .ctx_pend(ctx_pend), .ctx_base({BASE1, BASE0}),
    .retry_limit(retry_limit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .lnk_req(lnk_req), .lnk_pop(lnk_pop),
    .lnk_data(lnk_data), .lnk_ok(lnk_ok), .lnk_busy(lnk_busy),
    .lnk_err(lnk_err), .done(done), .done_ctx(done_ctx),
    .done_status(done_status)
  );

  function automatic logic [31:0] pat(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    if (a == BASE0)          return {16'h0, d_cnt[0]};
    if (a == BASE0 + 16'd1)  return {16'h0, d_paddr[0]};
    if (a == BASE1)          return {16'h0, d_cnt[1]};
    if (a == BASE1 + 16'd1)  return {16'h0, d_paddr[1]};
    return pat(a);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Host memory model: answers one held request per two cycles.
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    mem_rsp_err   = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
      end else if (mem_req) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(mem_addr);
        mem_rsp_err   = err_on && (mem_addr == err_addr);
        if (nlog < 32) rd_log[nlog] = mem_addr;
        nlog++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic set_desc(input int ctx, input int cnt, input int paddr);
    d_cnt[ctx]   = 16'(cnt);
    d_paddr[ctx] = 16'(paddr);
  endtask

  // fin: 0 answers ok after the busy attempts, 1 answers with a hard error.
  task automatic run_pkt(input int ctx, input int nbusy, input int fin,
                         input int exp_st, input int exp_reads,
                         input int exp_att, input string tag);
    int att = 0;
    int guard = 0;
    bit got = 1'b0;
    int cnt = int'(d_cnt[ctx]);
    logic [15:0] pa = d_paddr[ctx];
    logic [15:0] base = (ctx == 0) ? BASE0 : BASE1;
    nlog = 0;
    ctx_pend[ctx] = 1'b1;
    while (!got && guard < 3000) begin
      if (done) begin
        got = 1'b1;
      end else if (lnk_req) begin
        for (int i = 0; i < cnt; i++) begin
          lnk_pop = 1'b1;
          @(posedge clk); #1;
          lnk_pop = 1'b0;
          chk(lnk_data == pat(pa + 16'(i)), (att > 0) ? "R8" : "R4",
              "payload word", lnk_data, pat(pa + 16'(i)));
        end
        if (att < nbusy) lnk_busy = 1'b1;
        else if (fin != 0) lnk_err = 1'b1;
        else lnk_ok = 1'b1;
        @(posedge clk); #1;
        lnk_busy = 1'b0;
        lnk_err  = 1'b0;
        lnk_ok   = 1'b0;
        att++;
      end else begin
        @(posedge clk); #1;
        guard++;
      end
    end
    ctx_pend[ctx] = 1'b0;
    chk(got, "R11", "sequence ended", longint'(got), 1);
    chk(done_ctx == 1'(ctx), "R2", "served context", done_ctx, ctx);
    chk(done_status == 3'(exp_st), tag, "status", done_status, exp_st);
    chk(att == exp_att, tag, "link attempts", att, exp_att);
    chk(nlog == exp_reads, "R3", "read count", nlog, exp_reads);
    for (int i = 0; i < exp_reads && i < nlog && i < 32; i++) begin
      logic [15:0] e;
      e = (i == 0) ? base : (i == 1) ? base + 16'd1 : pa + 16'(i - 2);
      chk(rd_log[i] == e, "R3", "read address", rd_log[i], e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    rst = 1'b1;
    ctx_pend = '0;
    retry_limit = 4'd2;
    lnk_pop = 1'b0; lnk_ok = 1'b0; lnk_busy = 1'b0; lnk_err = 1'b0;
    err_on = 1'b0; err_addr = '0; nlog = 0;
    set_desc(0, 0, 0);
    set_desc(1, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(!mem_req && !lnk_req && !done, "R1", "outputs in reset",
        {mem_req, lnk_req, done}, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(!mem_req && !lnk_req && !done, "R1", "idle after reset",
        {mem_req, lnk_req, done}, 0);

    // Length sweep 0..DEPTH on alternating contexts; zero length covers R5.
    for (int c = 0; c <= DEPTH; c++) begin
      set_desc(c % 2, c, 16'h1000 + c * 32);
      run_pkt(c % 2, 0, 0, 0, 2 + c, 1, (c == 0) ? "R5" : "R11");
    end

    // R2: both pending, context 0 first.
    set_desc(0, 3, 16'h2000);
    set_desc(1, 2, 16'h2100);
    ctx_pend = 2'b11;
    run_pkt(0, 0, 0, 0, 5, 1, "R2");
    run_pkt(1, 0, 0, 0, 4, 1, "R2");

    // R6: length above DEPTH.
    set_desc(0, DEPTH + 1, 16'h2200);
    run_pkt(0, 0, 0, 5, 2, 0, "R6");

    // R7: descriptor and payload read errors.
    err_on = 1'b1;
    err_addr = BASE0;
    set_desc(0, 4, 16'h2300);
    run_pkt(0, 0, 0, 1, 1, 0, "R7");
    err_addr = BASE1 + 16'd1;
    set_desc(1, 4, 16'h2400);
    run_pkt(1, 0, 0, 1, 2, 0, "R7");
    err_addr = 16'h2502;
    set_desc(0, 6, 16'h2500);
    run_pkt(0, 0, 0, 2, 5, 0, "R7");
    err_on = 1'b0;
    // R12: clean packet after a partial fill.
    set_desc(0, 5, 16'h2600);
    run_pkt(0, 0, 0, 0, 7, 1, "R12");

    // R8 / R9: retry sweep over several limits.
    for (int l = 0; l < 4; l++) begin
      int lim = (l == 3) ? 15 : l;
      retry_limit = 4'(lim);
      for (int nb = 0; nb <= lim; nb += ((lim > 3) ? 5 : 1)) begin
        set_desc(1, 3, 16'h3000 + nb * 8);
        run_pkt(1, nb, 0, 0, 5, nb + 1, "R8");
      end
      set_desc(0, 4, 16'h3400);
      run_pkt(0, lim + 1, 0, 3, 6, lim + 1, "R9");
      set_desc(1, 2, 16'h3500 + l * 16);
      run_pkt(1, 0, 0, 0, 4, 1, "R12");
    end

    // R10: hard link error after one busy.
    retry_limit = 4'd2;
    set_desc(0, 6, 16'h3800);
    run_pkt(0, 1, 1, 4, 8, 2, "R10");
    set_desc(0, 3, 16'h3900);
    run_pkt(0, 0, 0, 0, 5, 1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule